// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave side of a four-wire serial memory: 512 bytes held in an on-chip byte array, reached over a mode-0 SPI link that has an active-low select, a pause pin and a write-protect pin. A host first sets a write-enable latch. It can then change two block-protect bits in a small status byte, or stream bytes into the array from any start address. Reads stream bytes back out from any start address. In both directions the address steps up by one per byte and wraps from the top of the array to zero.

All pins are sampled by the block's own clock through a short synchronizer, so SCK must run well below that clock. A half period of at least eight clock cycles is assumed. Serial data comes in and goes out on plain pins. There is no valid/ready handshake at the edge, and back-pressure does not arise: the host owns the serial clock, and holding it or pulling the pause pin low is the only way to stall a transfer. The output is not a true tri-state pin. `so_en` marks when `so` is being driven.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset `so_en` is 0 and the status byte reads 00h.
- R2: Command 06h sets the write-enable latch, which shows in status bit 1. Command 04h clears it.
- R3: The latch clears when select rises at the end of a write-data command (02h/0Ah) or a status-write command (01h).
- R4: With the latch clear, a write-data command changes no array byte and a status-write changes no bit.
- R5: Commands 02h/0Ah write and 03h/0Bh read. Opcode bit 3 is address bit 8, and the next byte carries address bits 7..0. All bytes travel MSB first, SI sampled on SCK rise, SO changed after SCK fall.
- R6: During a write, each data byte is stored as soon as its 8th bit is in. The address then steps up by one, wrapping from 1FFh to 000h, with no limit on byte count.
- R7: During a read, SO streams successive bytes from a stepping address that wraps from 1FFh to 000h. SI is ignored once the address is in.
- R8: The block-protect field is status bits 3:2. 00 guards nothing, 01 guards 180h-1FFh, 10 guards 100h-1FFh and 11 guards the whole array. Writes into a guarded range are dropped.
- R9: With `wp_n` low, neither the status byte nor any array byte can be written, even with the latch set.
- R10: Taking `hold_n` low while SCK is low pauses the transfer, and SCK edges during the pause are ignored. Raising `hold_n` while SCK is low resumes the transfer where it stopped.
- R11: `so_en` is 0 while select is high or a pause is active.
- R12: An undefined opcode is ignored, together with everything after it, until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples SCK |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_en | output | 1 | High while `so` is driven |

## Verification
A table of single-byte write/read-back pairs covers both address halves and the first and last bytes of each half. A mix-up of opcode bit 3 or of address-byte order would show as a wrong read-back in this table. Streaming writes and reads across 1FFh separate true wrapping from saturation or a stale address. Each protect setting is paired with one write just inside and one just outside its range, which shows the boundary. A read paused in mid-byte, with SCK toggling during the pause, shows whether edges leak through the hold. An undefined opcode sent with the latch set shows whether trailing bytes are acted on.

// File: rtl/spi_fram_pkg.sv
package spi_fram_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_RDSR, ST_WRSR, ST_SKIP
  } st_e;

  localparam logic [7:0] OP_SET_WE  = 8'h06;
  localparam logic [7:0] OP_CLR_WE  = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_RD_MEM  = 8'h03;
  localparam logic [7:0] OP_WR_MEM  = 8'h02;
  localparam logic [7:0] HI_BIT_MSK = 8'h08;
endpackage

// File: rtl/spi_fram_sync.sv
module spi_fram_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_hi,
  output logic cs_rise,
  output logic si_s,
  output logic wp_s,
  output logic held
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] IDLE_V = 5'b11010; // wp hold si cs sck

  logic [STAGES-1:0][NPIN-1:0] chain;
  logic [NPIN-1:0] s;
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{IDLE_V}};
    end else begin
      chain[0] <= {wp_n, hold_n, si, cs_n, sck};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign s = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      held  <= 1'b0;
    end else begin
      sck_q <= s[0];
      cs_q  <= s[1];
      if (s[1])       held <= 1'b0;
      else if (!s[0]) held <= ~s[3];
    end
  end

  assign sck_rise = s[0] & ~sck_q & ~held & ~s[1];
  assign sck_fall = ~s[0] & sck_q & ~held & ~s[1];
  assign cs_hi    = s[1];
  assign cs_rise  = s[1] & ~cs_q;
  assign si_s     = s[2];
  assign wp_s     = s[4];
endmodule

// File: rtl/spi_fram_prot.sv
module spi_fram_prot #(
  parameter int ADDR_W = 9
) (
  input  logic              wel,
  input  logic              wp_s,
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_ok,
  output logic              st_ok
);
  logic guarded;

  always_comb begin
    unique case (bp)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = &addr[ADDR_W-1 -: 2];
      2'b10:   guarded = addr[ADDR_W-1];
      default: guarded = 1'b1;
    endcase
  end

  assign st_ok  = wel & wp_s;
  assign arr_ok = st_ok & ~guarded;
endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave
  import spi_fram_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_en
);
  localparam int DW    = 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic sck_rise, sck_fall, cs_hi, cs_rise, si_s, wp_s, held;
  logic arr_ok, st_ok;
  st_e  state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, byte_in, out_sh, st_byte, rd_byte;
  logic [ADDR_W-1:0] addr, rd_addr, start_addr;
  logic wel, is_rd, hi, wcmd, adv, byte_done, mem_we;
  logic [1:0] bp;
  logic [DW-1:0] mem [DEPTH];

  spi_fram_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .si_s(si_s), .wp_s(wp_s), .held(held)
  );

  spi_fram_prot #(.ADDR_W(ADDR_W)) u_prot (
    .wel(wel), .wp_s(wp_s), .bp(bp), .addr(addr),
    .arr_ok(arr_ok), .st_ok(st_ok)
  );

  assign byte_in    = {sh[DW-2:0], si_s};
  assign byte_done  = sck_rise && (cnt == LAST);
  assign start_addr = ADDR_W'({hi, byte_in});
  assign rd_addr    = (state == ST_ADDR) ? start_addr : addr;
  assign rd_byte    = mem[rd_addr];
  assign mem_we     = byte_done && (state == ST_WDATA) && arr_ok && !cs_hi;

  always_comb begin
    st_byte      = '0;
    st_byte[3:2] = bp;
    st_byte[1]   = wel;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD; cnt <= '0; sh <= '0; addr <= '0; out_sh <= '0;
      wel <= 1'b0; bp <= 2'b00; is_rd <= 1'b0; hi <= 1'b0;
      wcmd <= 1'b0; adv <= 1'b0;
    end else if (cs_hi) begin
      if (cs_rise && wcmd) wel <= 1'b0;
      state <= ST_CMD; cnt <= '0; wcmd <= 1'b0; adv <= 1'b0;
    end else begin
      if (sck_rise) begin
        sh  <= byte_in;
        cnt <= cnt + 1'b1;
        if (state == ST_RDATA || state == ST_RDSR) adv <= 1'b1;
      end
      if (byte_done) begin
        unique case (state)
          ST_CMD: begin
            if (byte_in == OP_SET_WE) begin
              wel <= 1'b1; state <= ST_SKIP;
            end else if (byte_in == OP_CLR_WE) begin
              wel <= 1'b0; state <= ST_SKIP;
            end else if (byte_in == OP_RD_STAT) begin
              out_sh <= st_byte; state <= ST_RDSR;
            end else if (byte_in == OP_WR_STAT) begin
              wcmd <= 1'b1; state <= ST_WRSR;
            end else if ((byte_in & ~HI_BIT_MSK) == OP_RD_MEM) begin
              is_rd <= 1'b1; hi <= byte_in[3]; state <= ST_ADDR;
            end else if ((byte_in & ~HI_BIT_MSK) == OP_WR_MEM) begin
              is_rd <= 1'b0; hi <= byte_in[3]; wcmd <= 1'b1; state <= ST_ADDR;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            if (is_rd) begin
              out_sh <= rd_byte;
              addr   <= start_addr + 1'b1;
              state  <= ST_RDATA;
            end else begin
              addr  <= start_addr;
              state <= ST_WDATA;
            end
          end
          ST_WDATA: addr <= addr + 1'b1;
          ST_WRSR: begin
            if (st_ok) bp <= byte_in[3:2];
            state <= ST_SKIP;
          end
          default: ;
        endcase
      end
      if (sck_fall && adv) begin
        adv <= 1'b0;
        if (cnt == '0) begin
          if (state == ST_RDSR) begin
            out_sh <= st_byte;
          end else begin
            out_sh <= rd_byte;
            addr   <= addr + 1'b1;
          end
        end else begin
          out_sh <= {out_sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign so_en = !cs_hi && !held && (state == ST_RDATA || state == ST_RDSR);
  assign so    = so_en & out_sh[DW-1];
endmodule

// File: rtl/spi_fram_chk.sv
module spi_fram_chk
  import spi_fram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_hi,
  input logic              cs_rise,
  input logic              held,
  input logic              sck_rise,
  input logic              wcmd,
  input logic              wel,
  input logic [1:0]        bp,
  input logic              wp_s,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        cnt,
  input st_e               state,
  input logic              so_en
);
  // R3
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wcmd) |=> !wel);

  // R9
  wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_s |=> $stable(bp));

  // R4
  bp_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable(bp));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_hi) |=> $stable(addr));

  // R11
  so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_en);

  // R6
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !cs_hi && state == ST_WDATA && cnt == 3'd7)
      |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

bind spi_fram_slave spi_fram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_rise(cs_rise), .held(held),
  .sck_rise(sck_rise), .wcmd(wcmd), .wel(wel), .bp(bp), .wp_s(wp_s),
  .addr(addr), .cnt(cnt), .state(state), .so_en(so_en)
);

// File: tb/spi_fram_slave_tb.sv
module spi_fram_slave_tb;
  localparam int H = 8;
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {9'h000, 8'hA5}, {9'h0FF, 8'h3C}, {9'h100, 8'hC3},
    {9'h1FF, 8'h5A}, {9'h080, 8'h01}, {9'h17F, 8'h80}
  };

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, hold_n = 1, wp_n = 1;
  logic so, so_en;
  int total = 0, fails = 0;
  bit done = 0;

  spi_fram_slave u_dut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .si(si), .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r);
    si = b; wait_n(H); r = so; sck = 1; wait_n(H); sck = 0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      bitx(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic sel();
    cs_n = 0; wait_n(H);
  endtask

  task automatic desel();
    wait_n(H); cs_n = 1; wait_n(3 * H);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic wr1(input logic [8:0] a, input logic [7:0] v);
    logic [7:0] d;
    cmd1(8'h06);
    sel(); xfer(8'h02 | {4'b0, a[8], 3'b0}, d); xfer(a[7:0], d); xfer(v, d); desel();
  endtask

  task automatic rd1(input logic [8:0] a, output logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h03 | {4'b0, a[8], 3'b0}, d); xfer(a[7:0], d); xfer(8'hFF, v); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    wait_n(4); rst_n = 1; wait_n(4);

    // R1 reset state
    check("R1 so_en", {7'b0, so_en}, 8'h00);
    rdsr(d); check("R1 status", d, 8'h00);

    // R5 vector table: write then read back
    for (int i = 0; i < NV; i++) begin
      wr1(VEC[i][16:8], VEC[i][7:0]);
      rd1(VEC[i][16:8], d);
      check("R5 readback", d, VEC[i][7:0]);
    end

    // R3 latch cleared after write
    rdsr(d); check("R3 wel after write", d, 8'h00);

    // R2 set and clear latch
    cmd1(8'h06); rdsr(d); check("R2 wren", d, 8'h02);
    cmd1(8'h04); rdsr(d); check("R2 wrdi", d, 8'h00);

    // R4 write with latch clear
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h5A, d); desel();
    rd1(9'h000, d); check("R4 no wel", d, 8'hA5);

    // R6 streaming write across top
    cmd1(8'h06);
    sel(); xfer(8'h0A, d); xfer(8'hFE, d); xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d); desel();
    rd1(9'h1FE, d); check("R6 first", d, 8'h11);
    rd1(9'h000, d); check("R6 wrapped", d, 8'h33);

    // R7 streaming read across top, SI toggling
    sel(); xfer(8'h0B, d); xfer(8'hFF, d); xfer(8'hAA, d); xfer(8'h55, d2); desel();
    check("R7 byte0", d, 8'h22);
    check("R7 wrap", d2, 8'h33);

    // R9 write-protect pin
    wp_n = 0;
    wrsr(8'h0C); rdsr(d); check("R9 status locked", d, 8'h00);
    wr1(9'h080, 8'hEE); rd1(9'h080, d); check("R9 array locked", d, 8'h01);
    wp_n = 1;

    // R8 block protect
    wrsr(8'h04); rdsr(d); check("R8 bp01 status", d, 8'h04);
    wr1(9'h1FF, 8'h77); rd1(9'h1FF, d); check("R8 bp01 guarded", d, 8'h22);
    wr1(9'h17F, 8'h66); rd1(9'h17F, d); check("R8 bp01 open", d, 8'h66);
    wrsr(8'h08);
    wr1(9'h100, 8'h99); rd1(9'h100, d); check("R8 bp10 guarded", d, 8'hC3);
    wr1(9'h0FF, 8'h44); rd1(9'h0FF, d); check("R8 bp10 open", d, 8'h44);
    wrsr(8'h0C);
    wr1(9'h000, 8'h12); rd1(9'h000, d); check("R8 bp11 guarded", d, 8'h33);
    wrsr(8'h00);
    wr1(9'h000, 8'h12); rd1(9'h000, d); check("R8 bp00 open", d, 8'h12);

    // R10 pause mid-byte during read
    sel(); xfer(8'h03, d); xfer(8'h80, d);
    for (int i = 7; i >= 4; i--) begin
      logic r;
      bitx(1'b1, r); d2[i] = r;
    end
    hold_n = 0; wait_n(H);
    check("R11 so_en in hold", {7'b0, so_en}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      sck = 1; wait_n(H); sck = 0; wait_n(H);
    end
    hold_n = 1; wait_n(H);
    for (int i = 3; i >= 0; i--) begin
      logic r;
      bitx(1'b1, r); d2[i] = r;
    end
    desel();
    check("R10 resumed byte", d2, 8'h01);
    check("R11 so_en deselected", {7'b0, so_en}, 8'h00);

    // R12 undefined opcode with latch set
    cmd1(8'h06);
    sel(); xfer(8'hFF, d); xfer(8'h00, d); xfer(8'h02, d); xfer(8'h00, d); desel();
    rdsr(d); check("R12 latch kept", d, 8'h02);
    rd1(9'h000, d); check("R12 array kept", d, 8'h12);
    cmd1(8'h04);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule